// File: doc/BRIEF.md
# Scan Period Supervisor with Line-Group Tracking

This block paces the scan periods of a remote line scanner and keeps track of which group of lines the incoming status characters belong to. A free-running period timer marks a fixed scan window (six seconds at the nominal clock, shortened through a parameter for simulation). At every window boundary, and again whenever an end-of-scan character arrives, the block pulses a request toward the data link so that the next channel is interrogated. If a whole window passes with no end-of-scan character, a failure alarm is latched. It stays set until an operator clear is applied. A window that did see end-of-scan ends with a one-cycle pulse that tells the indicator logic to reset.

Received characters arrive as single-cycle strobes. Each strobe carries an end-of-group flag and an end-of-scan flag. For every ordinary character the block waits a settling delay and then raises a memory-execute strobe for exactly one cycle. When that cycle ends, the group counter steps if the character carried end-of-group, so groups may be of any size. The counter returns to zero on end-of-scan, or at the boundary of a window that saw none. The counter stops at its top value and records an overflow. While address mode is active, its raw value drives five memory-address bits.

Top module: `scan_supervisor`

## Requirements
- R1: While reset is asserted, every output is low, including all group-address bits.
- R2: `interrogate` is high for exactly the one cycle that follows either a window boundary or the capture of an end-of-scan character. Window boundaries fall every PERIOD_TICKS clock edges after reset is released.
- R3: `eos_fail` sets on the edge that closes a window in which no end-of-scan character was captured. It then holds until an edge that samples `alarm_clr` high. A new failure wins over a clear on the same edge.
- R4: A window in which at least one end-of-scan character was captured ends with `scan_done` high for one cycle, and this leaves `eos_fail` unchanged.
- R5: The group counter reads zero in the cycle after an end-of-scan character is captured. It also reads zero after the boundary of a window that had no end-of-scan character.
- R6: A character with the end-of-scan flag clear starts the settle delay. `mem_exec` is high for exactly one cycle, beginning SETTLE_CYC clock edges after the edge that captured the character. A character with the end-of-scan flag set never raises `mem_exec`.
- R7: A new character captured while an earlier one is still settling restarts the delay. Only the latest character produces a `mem_exec` cycle, and only its end-of-group flag counts.
- R8: On the edge that ends a `mem_exec` cycle, the group counter increments if that character's end-of-group flag was set. Otherwise the counter keeps its value.
- R9: The group counter holds at 31 instead of wrapping. A step requested at 31 sets `grp_ovf`, which stays set until reset.
- R10: `mem_addr_grp` equals the group counter while `addr_mode` is high, and is zero while it is low.
- R11: An end-of-scan capture on the same edge as a group step leaves the counter at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe for a received character |
| char_eog | input | 1 | End-of-group flag of the character |
| char_eos | input | 1 | End-of-scan flag of the character |
| addr_mode | input | 1 | Scan addressing active; gates the group bits onto the address |
| alarm_clr | input | 1 | Manual clear of the failure alarm |
| interrogate | output | 1 | One-cycle data request toward the data link |
| eos_fail | output | 1 | Latched missing end-of-scan alarm |
| scan_done | output | 1 | One-cycle indicator-reset pulse after a completed window |
| mem_exec | output | 1 | One-cycle memory-execute strobe per settled character |
| mem_addr_grp | output | GRP_W | Group bits of the memory address |
| grp_ovf | output | 1 | Sticky group-counter saturation flag |

## Verification
The hardest situations to reach are the ones that depend on where a window boundary falls. Examples are a clear that arrives in the very cycle a failure is declared, and a long run of end-of-group characters that must not be cut short by a boundary reset. The bench counts clock edges since reset, which gives it its own copy of the window phase. It aligns each scenario to a boundary and sends an end-of-scan character first, so the group counter survives the next boundary. To race the clear against the failure, it drives `alarm_clr` in the final cycle of a window that had no end-of-scan character. It also places an end-of-scan character on the exact edge that ends a memory-execute cycle.

// File: rtl/scan_sup_pkg.sv
package scan_sup_pkg;

  // width needed to hold values 0..n
  function automatic int unsigned cnt_width(int unsigned n);
    if (n < 2) return 1;
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/scan_period_timer.sv
module scan_period_timer #(
  parameter int unsigned PERIOD_TICKS = 750_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic period_end
);
  localparam int unsigned TW = scan_sup_pkg::cnt_width(PERIOD_TICKS - 1);
  localparam logic [TW-1:0] LAST = TW'(PERIOD_TICKS - 1);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tick_q <= '0;
    else if (tick_q == LAST) tick_q <= '0;
    else                     tick_q <= tick_q + 1'b1;
  end

  assign period_end = (tick_q == LAST);
endmodule

// File: rtl/scan_alarm.sv
module scan_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic period_end,
  input  logic eos_now,
  input  logic alarm_clr,
  output logic eos_miss,
  output logic eos_fail,
  output logic scan_done,
  output logic interrogate
);
  logic eos_seen_q;
  logic eos_hit;

  assign eos_hit  = eos_seen_q | eos_now;
  assign eos_miss = period_end & ~eos_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_seen_q  <= 1'b0;
      eos_fail    <= 1'b0;
      scan_done   <= 1'b0;
      interrogate <= 1'b0;
    end else begin
      eos_seen_q  <= period_end ? 1'b0 : eos_hit;
      scan_done   <= period_end & eos_hit;
      interrogate <= period_end | eos_now;
      if (eos_miss)       eos_fail <= 1'b1;
      else if (alarm_clr) eos_fail <= 1'b0;
    end
  end
endmodule

// File: rtl/settle_exec.sv
module settle_exec #(
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic char_valid,
  input  logic char_eog,
  input  logic char_eos,
  output logic mem_exec,
  output logic exec_eog
);
  localparam int unsigned SW = scan_sup_pkg::cnt_width(SETTLE_CYC);
  localparam logic [SW-1:0] LOAD = SW'(SETTLE_CYC);

  logic          pend_q;
  logic [SW-1:0] wait_q;
  logic          eog_q;
  logic          take;

  assign take     = char_valid & ~char_eos;
  assign exec_eog = mem_exec & eog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      wait_q   <= '0;
      eog_q    <= 1'b0;
      mem_exec <= 1'b0;
    end else begin
      mem_exec <= 1'b0;
      if (take) begin
        pend_q <= 1'b1;
        wait_q <= LOAD;
        eog_q  <= char_eog;
      end else if (pend_q) begin
        if (wait_q == SW'(1)) begin
          mem_exec <= 1'b1;
          pend_q   <= 1'b0;
        end else begin
          wait_q <= wait_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/group_counter.sv
module group_counter #(
  parameter int unsigned GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [GRP_W-1:0] grp,
  output logic             ovf
);
  // {overflow, next value} of a saturating increment
  function automatic logic [GRP_W:0] sat_step(logic [GRP_W-1:0] v);
    if (&v) return {1'b1, v};
    return {1'b0, v + 1'b1};
  endfunction

  logic [GRP_W:0] nxt;
  assign nxt = sat_step(grp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      grp <= '0;
    end else if (step) begin
      grp <= nxt[GRP_W-1:0];
      ovf <= ovf | nxt[GRP_W];
    end
  end
endmodule

// File: rtl/scan_supervisor.sv
module scan_supervisor #(
  parameter int unsigned PERIOD_TICKS = 750_000_000,
  parameter int unsigned SETTLE_CYC   = 3,
  parameter int unsigned GRP_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             char_valid,
  input  logic             char_eog,
  input  logic             char_eos,
  input  logic             addr_mode,
  input  logic             alarm_clr,
  output logic             interrogate,
  output logic             eos_fail,
  output logic             scan_done,
  output logic             mem_exec,
  output logic [GRP_W-1:0] mem_addr_grp,
  output logic             grp_ovf
);
  logic             period_end;
  logic             eos_now;
  logic             eos_miss;
  logic             exec_eog;
  logic             grp_clr;
  logic [GRP_W-1:0] grp_q;

  assign eos_now = char_valid & char_eos;
  assign grp_clr = eos_now | eos_miss;

  scan_period_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_end(period_end)
  );

  scan_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .period_end(period_end), .eos_now(eos_now),
    .alarm_clr(alarm_clr), .eos_miss(eos_miss), .eos_fail(eos_fail),
    .scan_done(scan_done), .interrogate(interrogate)
  );

  settle_exec #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_eog(char_eog),
    .char_eos(char_eos), .mem_exec(mem_exec), .exec_eog(exec_eog)
  );

  group_counter #(.GRP_W(GRP_W)) u_group (
    .clk(clk), .rst_n(rst_n), .clr(grp_clr), .step(exec_eog),
    .grp(grp_q), .ovf(grp_ovf)
  );

  assign mem_addr_grp = addr_mode ? grp_q : '0;
endmodule

// File: rtl/scan_supervisor_chk.sv
module scan_supervisor_chk #(
  parameter int unsigned GRP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_mode,
  input logic             alarm_clr,
  input logic             interrogate,
  input logic             eos_fail,
  input logic             scan_done,
  input logic             mem_exec,
  input logic [GRP_W-1:0] mem_addr_grp,
  input logic             grp_ovf,
  input logic             period_end,
  input logic             eos_now,
  input logic             eos_miss,
  input logic [GRP_W-1:0] grp_q
);
  assert_intg_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    interrogate |-> $past(period_end || eos_now));

  assert_fail_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_fail) |-> $past(eos_miss));

  assert_fail_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_fail && !alarm_clr) |=> eos_fail);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> ($past(period_end) && !$past(eos_miss)));

  assert_grp_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eos_now |=> (grp_q == '0));

  assert_exec_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_exec |=> !mem_exec);

  assert_grp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!eos_now && !eos_miss && !mem_exec) |=> (grp_q == $past(grp_q)));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_ovf |=> grp_ovf);

  assert_addr_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mode |-> (mem_addr_grp == '0));
endmodule

bind scan_supervisor scan_supervisor_chk #(.GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .alarm_clr(alarm_clr),
  .interrogate(interrogate), .eos_fail(eos_fail), .scan_done(scan_done),
  .mem_exec(mem_exec), .mem_addr_grp(mem_addr_grp), .grp_ovf(grp_ovf),
  .period_end(period_end), .eos_now(eos_now), .eos_miss(eos_miss), .grp_q(grp_q)
);

// File: tb/tb_scan_supervisor.sv
module tb_scan_supervisor;
  localparam int unsigned P  = 400;
  localparam int unsigned S  = 3;
  localparam int unsigned GW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic char_valid = 1'b0, char_eog = 1'b0, char_eos = 1'b0;
  logic addr_mode = 1'b0, alarm_clr = 1'b0;
  logic interrogate, eos_fail, scan_done, mem_exec, grp_ovf;
  logic [GW-1:0] mem_addr_grp;

  int checks = 0, errors = 0;
  int unsigned cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  scan_supervisor #(.PERIOD_TICKS(P), .SETTLE_CYC(S), .GRP_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_eog(char_eog),
    .char_eos(char_eos), .addr_mode(addr_mode), .alarm_clr(alarm_clr),
    .interrogate(interrogate), .eos_fail(eos_fail), .scan_done(scan_done),
    .mem_exec(mem_exec), .mem_addr_grp(mem_addr_grp), .grp_ovf(grp_ovf)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sync_boundary();
    do @(negedge clk); while (cyc % P != 0);
  endtask

  task automatic send_char(logic eog, logic eos);
    char_valid = 1'b1; char_eog = eog; char_eos = eos;
    @(negedge clk);
    char_valid = 1'b0; char_eog = 1'b0; char_eos = 1'b0;
  endtask

  task automatic settle_char(logic eog);
    send_char(eog, 1'b0);
    repeat (S + 1) @(negedge clk);
  endtask

  task automatic pulse_clear();
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
  endtask

  // boundary-aligned start with group at zero and end-of-scan seen
  task automatic start_clean();
    sync_boundary();
    addr_mode = 1'b1;
    send_char(1'b0, 1'b1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 interrogate", interrogate, 0);
    check("R1 eos_fail", eos_fail, 0);
    check("R1 scan_done", scan_done, 0);
    check("R1 mem_exec", mem_exec, 0);
    check("R1 grp_ovf", grp_ovf, 0);
    addr_mode = 1'b1; #1;
    check("R1 mem_addr_grp", mem_addr_grp, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_exec_timing();
    start_clean();
    send_char(1'b1, 1'b0);
    check("R6 exec low at capture", mem_exec, 0);
    for (int i = 1; i <= int'(S); i++) begin
      @(negedge clk);
      check("R6 exec timing", mem_exec, (i == int'(S)) ? 1 : 0);
    end
    check("R8 group before step", mem_addr_grp, 0);
    @(negedge clk);
    check("R6 exec one cycle", mem_exec, 0);
    check("R8 group stepped", mem_addr_grp, 1);
  endtask

  task automatic t_no_eog();
    start_clean();
    settle_char(1'b0);
    check("R8 no eog keeps group", mem_addr_grp, 0);
    settle_char(1'b1);
    settle_char(1'b1);
    check("R8 two eog steps", mem_addr_grp, 2);
  endtask

  task automatic t_eos_reset();
    start_clean();
    settle_char(1'b1);
    settle_char(1'b1);
    send_char(1'b0, 1'b1);
    check("R5 eos clears group", mem_addr_grp, 0);
    check("R2 interrogate after eos", interrogate, 1);
    @(negedge clk);
    check("R2 interrogate one cycle", interrogate, 0);
  endtask

  task automatic t_eos_no_exec();
    int pulses = 0;
    start_clean();
    send_char(1'b1, 1'b1);
    repeat (S + 3) begin
      @(negedge clk);
      if (mem_exec) pulses++;
    end
    check("R6 eos char no exec", pulses, 0);
  endtask

  task automatic t_restart();
    int pulses = 0;
    int first = -1;
    start_clean();
    send_char(1'b1, 1'b0);
    send_char(1'b0, 1'b0);
    for (int i = 1; i <= 2 * int'(S) + 4; i++) begin
      @(negedge clk);
      if (mem_exec) begin
        pulses++;
        if (first < 0) first = i;
      end
    end
    check("R7 single exec", pulses, 1);
    check("R7 exec from latest char", first, S);
    check("R7 latest eog used", mem_addr_grp, 0);
  endtask

  task automatic t_eos_beats_step();
    start_clean();
    settle_char(1'b1);
    check("R8 group one", mem_addr_grp, 1);
    send_char(1'b1, 1'b0);
    repeat (S) @(negedge clk);
    check("R11 exec active", mem_exec, 1);
    send_char(1'b0, 1'b1);
    check("R11 eos beats step", mem_addr_grp, 0);
  endtask

  task automatic t_addr_gate();
    start_clean();
    settle_char(1'b1);
    addr_mode = 1'b0; #1;
    check("R10 gated off", mem_addr_grp, 0);
    addr_mode = 1'b1; #1;
    check("R10 gated on", mem_addr_grp, 1);
  endtask

  task automatic t_alarm();
    start_clean();
    pulse_clear();
    check("R3 clear works", eos_fail, 0);
    settle_char(1'b1);
    settle_char(1'b1);
    sync_boundary();
    check("R4 done pulse", scan_done, 1);
    check("R4 fail untouched", eos_fail, 0);
    check("R2 interrogate at boundary", interrogate, 1);
    check("R5 no reset when eos seen", mem_addr_grp, 2);
    @(negedge clk);
    check("R4 done one cycle", scan_done, 0);
    check("R2 interrogate one cycle", interrogate, 0);
    do @(negedge clk); while (cyc % P != P - 1);
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
    check("R3 failure beats clear", eos_fail, 1);
    check("R5 boundary reset", mem_addr_grp, 0);
    check("R4 no done on miss", scan_done, 0);
    send_char(1'b0, 1'b1);
    sync_boundary();
    check("R3 fail latched", eos_fail, 1);
    check("R4 done with fail latched", scan_done, 1);
    pulse_clear();
    check("R3 manual clear", eos_fail, 0);
  endtask

  task automatic t_saturate();
    start_clean();
    repeat (31) settle_char(1'b1);
    check("R9 reach top", mem_addr_grp, 31);
    check("R9 no ovf yet", grp_ovf, 0);
    settle_char(1'b1);
    check("R9 hold top", mem_addr_grp, 31);
    check("R9 ovf set", grp_ovf, 1);
    send_char(1'b0, 1'b1);
    check("R9 cleared group", mem_addr_grp, 0);
    check("R9 ovf sticky", grp_ovf, 1);
  endtask

  initial begin
    t_reset();
    t_exec_timing();
    t_no_eog();
    t_eos_reset();
    t_eos_no_exec();
    t_restart();
    t_eos_beats_step();
    t_addr_gate();
    t_alarm();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule